// File: doc/BRIEF.md
# PHY Link and Mode Resolver

This controller runs once after reset. It finds an attached Ethernet PHY and works out what link the PHY has brought up. It reaches the PHY only through a simple management-read request port: it asks for one (PHY address, register) pair at a time, and a separate serial management master answers with the 16-bit value. The controller probes the address space for a responding device and classifies the device by its identifier word. It then polls the link status bit with a programmable gap between polls. Once the link is up, it reads the speed and duplex result from the register and bit layout that belongs to that device class.

The outcome is presented as a link flag, a two-bit speed code, a duplex flag and a PHY class code. A MAC configuration word is produced by taking a caller-supplied base word and rewriting its three link-mode bits. A one-cycle completion pulse marks the end of resolution, and an error flag reports that no PHY answered. When the integrated-transceiver input is asserted, the scan is skipped and link, speed and duplex are taken straight from an on-chip status word.

Top module: `phy_mode_resolver`

## Requirements
- R1: With `use_onchip` low, after reset the block reads register 1 at PHY addresses 1, 2, 3 … in ascending order, one address per request. It stops at the first address whose value is neither 0xFFFF nor 0x0000. A request (`rd_req` high) keeps its address and register unchanged until it is acknowledged by `rd_ack`.
- R2: If no address from 1 to 31 qualifies, `no_phy` is set, `link_ok` stays 0, `done` pulses, and no further request is issued.
- R3: The found PHY's register 2 is read and classified on `phy_type`: 0x0016→1, 0x0022→2, 0x0141→3, 0x0302→4, 0x0013→5, any other value→6. The value 0 means no PHY was classified (no PHY found, or the on-chip path).
- R4: After classification, register 1 of the found PHY is polled, with at least POLL_DELAY idle cycles between polls. The link is up when bit 2 is set. The block stops at the first poll that shows link up, or after MAX_POLLS polls; in the latter case `link_ok` is 0 and speed and duplex keep their reset values.
- R5: Classes 1, 2 and 4 read register 18. Class 1 uses bit 7 for 100M and bit 6 for full duplex. Classes 2 and 4 use bit 10 for 100M and bit 11 for full duplex. A clear speed bit means 10M.
- R6: Classes 3 and 5 read register 17, with bits 15:14 as the speed field. For class 3, 2'b10 means 1000M and 2'b01 means 100M. For class 5, 2'b11 means 1000M and 2'b10 means 100M. Any other field value means 10M. Full duplex is bit 13 for class 3 and bit 9 for class 5.
- R7: A class-6 PHY with link up sets `link_ok`, reads no speed register, and keeps the reset speed (10M) and half duplex.
- R8: `cfg_word` equals `cfg_base` with bits 19, 16 and 20 cleared. Bit 19 is then set for 10M, bit 16 for 1000M, and bit 20 for full duplex.
- R9: With `use_onchip` high, no request is issued. `link_ok` is bit 18 of `onchip_status`. When that bit is set, bit 10 selects 100M (else 10M) and bit 11 selects full duplex; otherwise speed and duplex keep their reset values.
- R10: `done` is high for exactly one cycle per reset, after all outputs hold their final values. No request follows it.
- R11: `speed` encodes 10M as 0, 100M as 1 and 1000M as 2, and never shows 3. Reset values are `speed`=0, `full_duplex`=0, `link_ok`=0, `no_phy`=0 and `phy_type`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; resolution starts when it is released |
| use_onchip | input | 1 | Selects the integrated-transceiver path |
| onchip_status | input | CFG_W | On-chip transceiver status word |
| rd_req | output | 1 | Management read request, held until acknowledged |
| rd_phy | output | ADDR_W | PHY address of the request |
| rd_reg | output | 5 | Register number of the request |
| rd_ack | input | 1 | One-cycle acknowledge carrying read data |
| rd_data | input | 16 | Read data, valid with `rd_ack` |
| cfg_base | input | CFG_W | MAC configuration word before mode bits are applied |
| cfg_word | output | CFG_W | Configuration word with link-mode bits applied |
| link_ok | output | 1 | Link is up |
| speed | output | 2 | Speed code (0=10M, 1=100M, 2=1000M) |
| full_duplex | output | 1 | Full-duplex flag |
| phy_type | output | 3 | PHY class code |
| done | output | 1 | One-cycle completion pulse |
| no_phy | output | 1 | No PHY answered the scan |

## Verification
A wrong sequencer state shows first on the request port, and it shows at once. The bench compares every request's address and register with the expected scan order, the identifier read, the poll count and the class-specific mode register, so a skipped address or a wrong register appears on the very next request. A wrong class or a wrong decode latch appears only as a wrong `speed`, `full_duplex` or `cfg_word` value when `done` pulses, and it stays there, so the outputs checked at completion catch it. A stuck or repeated completion shows as a missing or extra `done` pulse, or as a request after `done`, within the few cycles that are watched after completion.

// File: rtl/phy_res_pkg.sv
package phy_res_pkg;

   localparam int MREG_W = 5;

   localparam logic [MREG_W-1:0] MREG_STATUS = 5'd1;
   localparam logic [MREG_W-1:0] MREG_ID     = 5'd2;
   localparam logic [MREG_W-1:0] MREG_EXT17  = 5'd17;
   localparam logic [MREG_W-1:0] MREG_EXT18  = 5'd18;

   typedef enum logic [2:0] {
      KIND_NONE  = 3'd0,
      KIND_S     = 3'd1,
      KIND_A     = 3'd2,
      KIND_M     = 3'd3,
      KIND_Y     = 3'd4,
      KIND_L     = 3'd5,
      KIND_OTHER = 3'd6
   } phy_kind_t;

   typedef enum logic [1:0] {
      SPD_10   = 2'd0,
      SPD_100  = 2'd1,
      SPD_1000 = 2'd2
   } link_spd_t;

   typedef enum logic [2:0] {
      SEQ_START,
      SEQ_SCAN,
      SEQ_ID,
      SEQ_POLL,
      SEQ_WAIT,
      SEQ_MODE,
      SEQ_FIN,
      SEQ_IDLE
   } seq_t;

   function automatic phy_kind_t kind_from_id(input logic [15:0] id);
      case (id)
         16'h0016: return KIND_S;
         16'h0022: return KIND_A;
         16'h0141: return KIND_M;
         16'h0302: return KIND_Y;
         16'h0013: return KIND_L;
         default:  return KIND_OTHER;
      endcase
   endfunction

endpackage

// File: rtl/phy_mode_decode.sv
module phy_mode_decode
   import phy_res_pkg::*;
(
   input  phy_kind_t          kind,
   input  logic [15:0]        vs_word,
   output link_spd_t          spd,
   output logic               fdx,
   output logic [MREG_W-1:0]  vs_reg,
   output logic               has_vs
);

   always_comb begin
      spd    = SPD_10;
      fdx    = 1'b0;
      vs_reg = MREG_EXT18;
      has_vs = 1'b0;
      case (kind)
         KIND_S: begin
            has_vs = 1'b1;
            spd    = vs_word[7] ? SPD_100 : SPD_10;
            fdx    = vs_word[6];
         end
         KIND_A, KIND_Y: begin
            has_vs = 1'b1;
            spd    = vs_word[10] ? SPD_100 : SPD_10;
            fdx    = vs_word[11];
         end
         KIND_M: begin
            has_vs = 1'b1;
            vs_reg = MREG_EXT17;
            case (vs_word[15:14])
               2'b10:   spd = SPD_1000;
               2'b01:   spd = SPD_100;
               default: spd = SPD_10;
            endcase
            fdx = vs_word[13];
         end
         KIND_L: begin
            has_vs = 1'b1;
            vs_reg = MREG_EXT17;
            case (vs_word[15:14])
               2'b11:   spd = SPD_1000;
               2'b10:   spd = SPD_100;
               default: spd = SPD_10;
            endcase
            fdx = vs_word[9];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
   parameter int DELAY = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   if (DELAY < 1) begin : g_bad_delay
      $error("phy_poll_timer: DELAY must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign expired = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/phy_cfg_merge.sv
module phy_cfg_merge
   import phy_res_pkg::*;
#(
   parameter int CFG_W     = 32,
   parameter int BIT_10M   = 19,
   parameter int BIT_1000M = 16,
   parameter int BIT_FDX   = 20
) (
   input  logic [CFG_W-1:0] cfg_base,
   input  link_spd_t        spd,
   input  logic             fdx,
   output logic [CFG_W-1:0] cfg_word
);

   localparam logic [CFG_W-1:0] ONE   = CFG_W'(1);
   localparam logic [CFG_W-1:0] M10   = ONE << BIT_10M;
   localparam logic [CFG_W-1:0] M1000 = ONE << BIT_1000M;
   localparam logic [CFG_W-1:0] MFDX  = ONE << BIT_FDX;
   localparam logic [CFG_W-1:0] CLR   = M10 | M1000 | MFDX;

   if (BIT_10M >= CFG_W || BIT_1000M >= CFG_W || BIT_FDX >= CFG_W) begin : g_bad_pos
      $error("phy_cfg_merge: mode bit outside the configuration word");
   end
   if (BIT_10M == BIT_1000M || BIT_10M == BIT_FDX || BIT_1000M == BIT_FDX) begin : g_bad_dup
      $error("phy_cfg_merge: mode bit positions must differ");
   end

   always_comb begin
      cfg_word = cfg_base & ~CLR;
      if (spd == SPD_10)   cfg_word = cfg_word | M10;
      if (spd == SPD_1000) cfg_word = cfg_word | M1000;
      if (fdx)             cfg_word = cfg_word | MFDX;
   end

endmodule

// File: rtl/phy_mode_resolver.sv
module phy_mode_resolver
   import phy_res_pkg::*;
#(
   parameter int ADDR_W          = 5,
   parameter int DATA_W          = 16,
   parameter int CFG_W           = 32,
   parameter int FIRST_ADDR      = 1,
   parameter int LAST_ADDR       = 31,
   parameter int MAX_POLLS       = 4096,
   parameter int POLL_DELAY      = 1000,
   parameter int LINK_BIT        = 2,
   parameter int ONCHIP_LINK_BIT = 18,
   parameter int ONCHIP_100_BIT  = 10,
   parameter int ONCHIP_FDX_BIT  = 11,
   parameter int BIT_10M         = 19,
   parameter int BIT_1000M       = 16,
   parameter int BIT_FDX         = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              use_onchip,
   input  logic [CFG_W-1:0]  onchip_status,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_phy,
   output logic [MREG_W-1:0] rd_reg,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [CFG_W-1:0]  cfg_base,
   output logic [CFG_W-1:0]  cfg_word,
   output logic              link_ok,
   output logic [1:0]        speed,
   output logic              full_duplex,
   output logic [2:0]        phy_type,
   output logic              done,
   output logic              no_phy
);

   localparam int PW = $clog2(MAX_POLLS + 1);
   localparam logic [PW-1:0]     POLL_LAST = PW'(MAX_POLLS - 1);
   localparam logic [ADDR_W-1:0] A_FIRST   = ADDR_W'(FIRST_ADDR);
   localparam logic [ADDR_W-1:0] A_LAST    = ADDR_W'(LAST_ADDR);

   if (DATA_W != 16) begin : g_bad_data
      $error("phy_mode_resolver: DATA_W must be 16");
   end
   if (FIRST_ADDR < 1 || FIRST_ADDR > LAST_ADDR || LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("phy_mode_resolver: scan range does not fit ADDR_W");
   end
   if (MAX_POLLS < 1) begin : g_bad_polls
      $error("phy_mode_resolver: MAX_POLLS must be at least 1");
   end
   if (LINK_BIT >= DATA_W) begin : g_bad_link
      $error("phy_mode_resolver: LINK_BIT outside data word");
   end
   if (ONCHIP_LINK_BIT >= CFG_W || ONCHIP_100_BIT >= CFG_W || ONCHIP_FDX_BIT >= CFG_W) begin : g_bad_onchip
      $error("phy_mode_resolver: on-chip status bit outside word");
   end

   seq_t              state_q;
   logic [ADDR_W-1:0] addr_q;
   phy_kind_t         kind_q;
   logic [PW-1:0]     polls_q;
   logic              link_q;
   link_spd_t         spd_q;
   logic              fdx_q;
   logic              done_q;
   logic              nophy_q;

   link_spd_t          dec_spd;
   logic               dec_fdx;
   logic [MREG_W-1:0]  dec_reg;
   logic               dec_has;
   logic               gap_over;
   logic               id_valid;

   phy_mode_decode i_decode (
      .kind    (kind_q),
      .vs_word (rd_data),
      .spd     (dec_spd),
      .fdx     (dec_fdx),
      .vs_reg  (dec_reg),
      .has_vs  (dec_has)
   );

   phy_poll_timer #(.DELAY(POLL_DELAY)) i_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == SEQ_WAIT),
      .expired (gap_over)
   );

   phy_cfg_merge #(
      .CFG_W     (CFG_W),
      .BIT_10M   (BIT_10M),
      .BIT_1000M (BIT_1000M),
      .BIT_FDX   (BIT_FDX)
   ) i_merge (
      .cfg_base (cfg_base),
      .spd      (spd_q),
      .fdx      (fdx_q),
      .cfg_word (cfg_word)
   );

   assign id_valid = (rd_data != {DATA_W{1'b1}}) && (rd_data != {DATA_W{1'b0}});

   assign rd_req = (state_q == SEQ_SCAN) || (state_q == SEQ_ID) ||
                   (state_q == SEQ_POLL) || (state_q == SEQ_MODE);
   assign rd_phy = addr_q;

   always_comb begin
      case (state_q)
         SEQ_ID:   rd_reg = MREG_ID;
         SEQ_MODE: rd_reg = dec_reg;
         default:  rd_reg = MREG_STATUS;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_START;
         addr_q  <= A_FIRST;
         kind_q  <= KIND_NONE;
         polls_q <= '0;
         link_q  <= 1'b0;
         spd_q   <= SPD_10;
         fdx_q   <= 1'b0;
         done_q  <= 1'b0;
         nophy_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            SEQ_START: begin
               if (use_onchip) begin
                  link_q <= onchip_status[ONCHIP_LINK_BIT];
                  if (onchip_status[ONCHIP_LINK_BIT]) begin
                     spd_q <= onchip_status[ONCHIP_100_BIT] ? SPD_100 : SPD_10;
                     fdx_q <= onchip_status[ONCHIP_FDX_BIT];
                  end
                  state_q <= SEQ_FIN;
               end else begin
                  addr_q  <= A_FIRST;
                  state_q <= SEQ_SCAN;
               end
            end
            SEQ_SCAN: if (rd_ack) begin
               if (id_valid) begin
                  state_q <= SEQ_ID;
               end else if (addr_q == A_LAST) begin
                  nophy_q <= 1'b1;
                  state_q <= SEQ_FIN;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            SEQ_ID: if (rd_ack) begin
               kind_q  <= kind_from_id(rd_data);
               polls_q <= '0;
               state_q <= SEQ_POLL;
            end
            SEQ_POLL: if (rd_ack) begin
               if (rd_data[LINK_BIT]) begin
                  link_q  <= 1'b1;
                  state_q <= dec_has ? SEQ_MODE : SEQ_FIN;
               end else if (polls_q == POLL_LAST) begin
                  state_q <= SEQ_FIN;
               end else begin
                  polls_q <= polls_q + 1'b1;
                  state_q <= SEQ_WAIT;
               end
            end
            SEQ_WAIT: if (gap_over) state_q <= SEQ_POLL;
            SEQ_MODE: if (rd_ack) begin
               spd_q   <= dec_spd;
               fdx_q   <= dec_fdx;
               state_q <= SEQ_FIN;
            end
            SEQ_FIN: begin
               done_q  <= 1'b1;
               state_q <= SEQ_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign link_ok     = link_q;
   assign speed       = spd_q;
   assign full_duplex = fdx_q;
   assign phy_type    = kind_q;
   assign done        = done_q;
   assign no_phy      = nophy_q;

endmodule

// File: rtl/phy_mode_resolver_chk.sv
module phy_mode_resolver_chk #(
   parameter int ADDR_W     = 5,
   parameter int CFG_W      = 32,
   parameter int FIRST_ADDR = 1,
   parameter int BIT_10M    = 19,
   parameter int BIT_1000M  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              use_onchip,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_phy,
   input logic [4:0]        rd_reg,
   input logic              rd_ack,
   input logic [CFG_W-1:0]  cfg_word,
   input logic              link_ok,
   input logic [1:0]        speed,
   input logic              done,
   input logic              no_phy
);

   logic fin_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    fin_seen <= 1'b0;
      else if (done) fin_seen <= 1'b1;
   end

   assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_phy) && $stable(rd_reg)));

   assert_scan_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_phy >= ADDR_W'(FIRST_ADDR)));

   assert_nophy_nolink_R2: assert property (@(posedge clk) disable iff (!rst_n)
      no_phy |-> !link_ok);

   assert_cfg_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((speed == 2'd0) == cfg_word[BIT_10M]) && ((speed == 2'd2) == cfg_word[BIT_1000M]));

   assert_onchip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      use_onchip |-> !rd_req);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_quiet_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fin_seen |-> (!rd_req && !done));

   assert_speed_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      speed != 2'd3);

endmodule

bind phy_mode_resolver phy_mode_resolver_chk #(
   .ADDR_W     (ADDR_W),
   .CFG_W      (CFG_W),
   .FIRST_ADDR (FIRST_ADDR),
   .BIT_10M    (BIT_10M),
   .BIT_1000M  (BIT_1000M)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .use_onchip (use_onchip),
   .rd_req     (rd_req),
   .rd_phy     (rd_phy),
   .rd_reg     (rd_reg),
   .rd_ack     (rd_ack),
   .cfg_word   (cfg_word),
   .link_ok    (link_ok),
   .speed      (speed),
   .done       (done),
   .no_phy     (no_phy)
);

// File: tb/test_phy_mode_resolver.sv
`timescale 1ns/1ps
module test_phy_mode_resolver;

   localparam int MAXP = 12;
   localparam int PD   = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        use_onchip = 1'b0;
   logic [31:0] onchip_status = '0;
   logic        rd_req;
   logic [4:0]  rd_phy;
   logic [4:0]  rd_reg;
   logic        rd_ack = 1'b0;
   logic [15:0] rd_data = '0;
   logic [31:0] cfg_base = '0;
   logic [31:0] cfg_word;
   logic        link_ok;
   logic [1:0]  speed;
   logic        full_duplex;
   logic [2:0]  phy_type;
   logic        done;
   logic        no_phy;

   phy_mode_resolver #(.MAX_POLLS(MAXP), .POLL_DELAY(PD)) i_phy_mode_resolver (
      .clk(clk), .rst_n(rst_n), .use_onchip(use_onchip), .onchip_status(onchip_status),
      .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg), .rd_ack(rd_ack), .rd_data(rd_data),
      .cfg_base(cfg_base), .cfg_word(cfg_word), .link_ok(link_ok), .speed(speed),
      .full_duplex(full_duplex), .phy_type(phy_type), .done(done), .no_phy(no_phy)
   );

   always #4 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // scenario description
   int          sc_p;
   logic [15:0] sc_id, sc_r17, sc_r18;
   int          sc_link_after;
   int          sc_lat;

   // responder observations
   int scan_reads, order_bad, id_reads, poll_reads, mode_reads, wrong_addr, gap_bad;
   int mode_reg_last, done_cnt, late_req, cyc, last_poll_cyc;
   bit id_seen;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_kind(input logic [15:0] id);
      if (id == 16'h0016) return 3'd1;
      if (id == 16'h0022) return 3'd2;
      if (id == 16'h0141) return 3'd3;
      if (id == 16'h0302) return 3'd4;
      if (id == 16'h0013) return 3'd5;
      return 3'd6;
   endfunction

   function automatic logic [1:0] exp_spd(input logic [2:0] k, input logic [15:0] r17, input logic [15:0] r18);
      case (k)
         3'd1: return r18[7] ? 2'd1 : 2'd0;
         3'd2, 3'd4: return r18[10] ? 2'd1 : 2'd0;
         3'd3: return (r17[15:14] == 2'b10) ? 2'd2 : (r17[15:14] == 2'b01) ? 2'd1 : 2'd0;
         3'd5: return (r17[15:14] == 2'b11) ? 2'd2 : (r17[15:14] == 2'b10) ? 2'd1 : 2'd0;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic exp_fd(input logic [2:0] k, input logic [15:0] r17, input logic [15:0] r18);
      case (k)
         3'd1: return r18[6];
         3'd2, 3'd4: return r18[11];
         3'd3: return r17[13];
         3'd5: return r17[9];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [31:0] exp_cfg(input logic [31:0] b, input logic [1:0] s, input logic f);
      logic [31:0] w;
      w = b & ~32'h0019_0000;
      if (s == 2'd0) w[19] = 1'b1;
      if (s == 2'd2) w[16] = 1'b1;
      if (f)         w[20] = 1'b1;
      return w;
   endfunction

   // cycle counter and done / late-request monitor
   initial forever begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
         if (done_cnt > 0 && rd_req) late_req++;
         if (done) done_cnt++;
      end
   end

   // management read responder
   initial forever begin
      @(negedge clk);
      rd_ack = 1'b0;
      if (rst_n && rd_req) begin
         int phy, rg;
         logic [15:0] d;
         phy = int'(rd_phy);
         rg  = int'(rd_reg);
         repeat ($urandom_range(0, sc_lat)) @(negedge clk);
         d = 16'h0000;
         if (rg == 1 && !id_seen) begin
            scan_reads++;
            if (phy != scan_reads) order_bad++;
            d = (phy == sc_p) ? 16'h7809 : (phy[0] ? 16'hFFFF : 16'h0000);
         end else if (rg == 2) begin
            id_reads++;
            id_seen = 1;
            if (phy != sc_p) wrong_addr++;
            d = sc_id;
         end else if (rg == 1) begin
            poll_reads++;
            if (phy != sc_p) wrong_addr++;
            if (poll_reads > 1 && (cyc - last_poll_cyc) < PD + 1) gap_bad++;
            last_poll_cyc = cyc;
            d = 16'h7809 | ((poll_reads >= sc_link_after) ? 16'h0004 : 16'h0000);
         end else if (rg == 17 || rg == 18) begin
            mode_reads++;
            mode_reg_last = rg;
            if (phy != sc_p) wrong_addr++;
            d = (rg == 17) ? sc_r17 : sc_r18;
         end
         rd_data = d;
         rd_ack  = 1'b1;
      end
   end

   task automatic run_scn(input bit onc, input logic [31:0] st, input int p, input logic [15:0] id,
                          input int la, input logic [15:0] r17, input logic [15:0] r18,
                          input logic [31:0] base);
      logic [2:0]  k;
      logic        lk;
      logic [1:0]  es;
      logic        ef;
      int          wait_n;
      rst_n = 1'b0;
      use_onchip = onc; onchip_status = st; cfg_base = base;
      sc_p = p; sc_id = id; sc_link_after = la; sc_r17 = r17; sc_r18 = r18;
      sc_lat = $urandom_range(0, 2);
      scan_reads = 0; order_bad = 0; id_reads = 0; poll_reads = 0; mode_reads = 0;
      wrong_addr = 0; gap_bad = 0; mode_reg_last = 0; done_cnt = 0; late_req = 0;
      id_seen = 0; last_poll_cyc = 0;
      repeat (3) @(negedge clk);
      // reset state (R11, R8)
      chk("R11 reset link", 32'(link_ok), 32'd0);
      chk("R11 reset speed", 32'(speed), 32'd0);
      chk("R11 reset flags", {28'd0, full_duplex, no_phy, done, rd_req}, 32'd0);
      chk("R8 reset cfg", cfg_word, exp_cfg(base, 2'd0, 1'b0));
      rst_n = 1'b1;
      wait_n = 0;
      while (done_cnt == 0 && wait_n < 5000) begin
         @(negedge clk);
         wait_n++;
      end
      repeat (8) @(negedge clk);
      chk("R10 done pulses", 32'(done_cnt), 32'd1);
      chk("R10 requests after done", 32'(late_req), 32'd0);
      if (onc) begin
         lk = st[18];
         es = (lk && st[10]) ? 2'd1 : 2'd0;
         ef = lk && st[11];
         chk("R9 no requests", 32'(scan_reads + id_reads + poll_reads + mode_reads), 32'd0);
         chk("R9 link", 32'(link_ok), 32'(lk));
         chk("R9 speed", 32'(speed), 32'(es));
         chk("R9 duplex", 32'(full_duplex), 32'(ef));
         chk("R9 type", 32'(phy_type), 32'd0);
         chk("R8 cfg", cfg_word, exp_cfg(base, es, ef));
      end else if (p == 0) begin
         chk("R2 scan reads", 32'(scan_reads), 32'd31);
         chk("R1 scan order", 32'(order_bad), 32'd0);
         chk("R2 no_phy", 32'(no_phy), 32'd1);
         chk("R2 link", 32'(link_ok), 32'd0);
         chk("R2 other reads", 32'(id_reads + poll_reads + mode_reads), 32'd0);
         chk("R8 cfg", cfg_word, exp_cfg(base, 2'd0, 1'b0));
      end else begin
         k  = exp_kind(id);
         lk = (la <= MAXP);
         es = (lk && k != 3'd6) ? exp_spd(k, r17, r18) : 2'd0;
         ef = (lk && k != 3'd6) ? exp_fd(k, r17, r18) : 1'b0;
         chk("R1 scan reads", 32'(scan_reads), 32'(p));
         chk("R1 scan order", 32'(order_bad), 32'd0);
         chk("R3 id reads", 32'(id_reads), 32'd1);
         chk("R3 type", 32'(phy_type), 32'(k));
         chk("R4 poll reads", 32'(poll_reads), 32'(lk ? la : MAXP));
         chk("R4 poll gap", 32'(gap_bad), 32'd0);
         chk("R4 link", 32'(link_ok), 32'(lk));
         chk("R1 address", 32'(wrong_addr), 32'd0);
         chk("R2 no_phy clear", 32'(no_phy), 32'd0);
         if (lk && k != 3'd6) begin
            chk((k == 3'd3 || k == 3'd5) ? "R6 mode register" : "R5 mode register",
                32'(mode_reg_last), (k == 3'd3 || k == 3'd5) ? 32'd17 : 32'd18);
         end else begin
            chk("R7 no mode read", 32'(mode_reads), 32'd0);
         end
         chk((k == 3'd3 || k == 3'd5) ? "R6 speed" : "R5 R7 R11 speed", 32'(speed), 32'(es));
         chk((k == 3'd3 || k == 3'd5) ? "R6 duplex" : "R5 R7 duplex", 32'(full_duplex), 32'(ef));
         chk("R8 cfg", cfg_word, exp_cfg(base, es, ef));
      end
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (2) @(negedge clk);
      // directed corners
      run_scn(0, 0, 1,  16'h0016, 1, 16'h0, 16'h00C0, 32'hFFFF_FFFF); // S 100 full
      run_scn(0, 0, 5,  16'h0022, 3, 16'h0, 16'h0400, 32'h0000_0000); // A 100 half
      run_scn(0, 0, 31, 16'h0302, 2, 16'h0, 16'h0800, 32'h1234_5678); // Y 10 full, last address
      run_scn(0, 0, 3,  16'h0141, 1, 16'hA000, 16'h0, 32'h00FF_00FF); // M 1000 full
      run_scn(0, 0, 4,  16'h0141, 2, 16'hC000, 16'h0, 32'hFFFF_FFFF); // M field 11 -> 10M
      run_scn(0, 0, 2,  16'h0013, 1, 16'hC200, 16'h0, 32'h0);         // L 1000 full
      run_scn(0, 0, 7,  16'h0013, 4, 16'h8000, 16'h0, 32'h0);         // L 100 half
      run_scn(0, 0, 9,  16'h1234, 2, 16'hFFFF, 16'hFFFF, 32'h0);      // other
      run_scn(0, 0, 0,  16'h0016, 1, 16'h0, 16'h0, 32'hA5A5_A5A5);    // no PHY
      run_scn(0, 0, 6,  16'h0141, MAXP + 1, 16'hA000, 16'h0, 32'h0);  // no link
      run_scn(0, 0, 6,  16'h0141, MAXP, 16'h6000, 16'h0, 32'h0);      // link on final poll
      run_scn(1, 32'h0004_0C00, 0, 16'h0, 1, 16'h0, 16'h0, 32'hFFFF_FFFF); // on-chip up
      run_scn(1, 32'h0000_0C00, 0, 16'h0, 1, 16'h0, 16'h0, 32'h0);         // on-chip down
      // constrained random
      for (int i = 0; i < 25; i++) begin
         logic [15:0] ids [7];
         ids = '{16'h0016, 16'h0022, 16'h0141, 16'h0302, 16'h0013, 16'h4242, 16'h0001};
         run_scn($urandom_range(0, 7) == 0, $urandom,
                 $urandom_range(0, 31), ids[$urandom_range(0, 6)],
                 $urandom_range(1, MAXP + 2), 16'($urandom), 16'($urandom), $urandom);
      end
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule